// File: doc/BRIEF.md
# Compare match timer channel

This block is one channel of a periodic interval timer. An up-counter advances once per period of a prescaled count clock. When it has reached the value held in the compare register, the next count returns it to zero and sets a sticky match flag. If the interrupt enable is set, the flag drives an interrupt line, which stays high until software clears the flag. The counting period is therefore compare value plus one count-clock ticks.

Software reaches four registers through a small synchronous port. Each register has a two-bit word index:

| Index | Byte offset | Register |
|---|---|---|
| 0 | 0 | run-control register, shared with other channels |
| 1 | 2 | control/status register |
| 2 | 4 | counter |
| 3 | 6 | compare |

The run-control register is a plain storage word. One bit of it, chosen by a parameter, gates this channel. Counter writes cross into the slow counting domain. They take effect only after two count-clock ticks, so software polls the counter until the written value shows up.

Top module: `cmt_channel`

## Requirements
- R1: After reset, the run-control register and the control/status register read 0. The counter reads 0, the compare register reads all ones, and `irq` is low.
- R2: The run-control register (word index 0) reads back exactly as written. Only bit `START_BIT` (default 0) runs the channel. While that bit is 0 and no counter write is pending, the counter holds its value.
- R3: Control/status bits [1:0] select the count clock: 0 gives clk/8, 1 gives clk/32, 2 gives clk/128 and 3 gives clk/512. The prescaler restarts from zero whenever the channel is idle. For a run bit that is set at one write edge and cleared at an edge G cycles later, the counter advances floor(G/divide) times.
- R4: On a count-clock tick, a counter equal to the compare register goes to 0 and sets the match flag (control/status bit 7). Any other counter value increments by one.
- R5: A control/status write with bit 7 at 0 clears the match flag. A write with bit 7 at 1 leaves the flag unchanged and never sets it. A match in the same cycle as a clearing write leaves the flag set.
- R6: `irq` is the registered AND of the match flag and the interrupt enable (control/status bit 6). Writing 0 to the control/status register drops `irq`.
- R7: A counter write (word index 2) is loaded on the second count-clock tick after the write. Reads between the write and that tick return the old count. The prescaler runs for a pending load even while the channel is stopped.
- R8: The control/status register reads as {bit 7 flag, bit 6 enable, bits 5:2 zero, bits 1:0 divider select}. The upper bits read as zero. `bus_rdata` is registered: it is valid the cycle after a read strobe and holds the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Match interrupt, level |

## Verification
The bench predicts the exact number of count ticks from the edges at which the run bit is set and cleared. A prescaler that does not restart, or that is off by one, therefore shows up as a wrong counter value or a wrong flag state. A compare of zero makes every tick a match. With that setting the bench clears the flag in exactly a match cycle, which catches a design that lets the software clear win and loses the event. The counter is read one tick after a counter write and again after the second tick. A design that loads at once, or never loads while stopped, returns the wrong value at one of the two reads. A flag-preserving write is also issued while the flag is clear, which catches a design that sets the flag from write data.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    REG_RUN   = 2'd0,
    REG_CSR   = 2'd1,
    REG_COUNT = 2'd2,
    REG_MATCH = 2'd3
  } reg_sel_e;

  localparam int FLAG_POS = 7;
  localparam int IE_POS   = 6;
  localparam int SEL_W    = 2;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int SH0  = 3,
  parameter int STEP = 2,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  localparam int PW = SH0 + STEP * ((1 << SELW) - 1);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] mask;

  always_comb begin
    mask = PW'((1 << (SH0 + STEP * int'(sel))) - 1);
    tick = active && ((pcnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_cnt,
  input  logic          wr_cmp,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output logic          pending,
  output logic          match_evt
);
  localparam logic [1:0] SYNC_TICKS = 2'd2;

  logic [1:0]    stage;
  logic [CW-1:0] load_val;

  always_comb begin
    pending   = (stage != 2'd0);
    match_evt = tick && run && !wr_cnt && (stage != 2'd1) && (cnt == cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cmp      <= '1;
      stage    <= 2'd0;
      load_val <= '0;
    end else begin
      if (wr_cmp) cmp <= wdata;
      if (wr_cnt) begin
        load_val <= wdata;
        stage    <= SYNC_TICKS;
      end else if (tick) begin
        if (stage != 2'd0) stage <= stage - 2'd1;
        if (stage == 2'd1)   cnt <= load_val;
        else if (run)        cnt <= (cnt == cmp) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl #(
  parameter int DW        = 16,
  parameter int START_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_run,
  input  logic          wr_csr,
  input  logic [DW-1:0] wdata,
  input  logic          match_evt,
  output logic [DW-1:0] run_reg,
  output logic          run,
  output logic          flag,
  output logic          ie,
  output logic [1:0]    cks,
  output logic          irq
);
  import cmt_pkg::*;

  logic       flag_n, ie_n;
  logic [1:0] cks_n;

  always_comb begin
    flag_n = (wr_csr ? (flag & wdata[FLAG_POS]) : flag) | match_evt;
    ie_n   = wr_csr ? wdata[IE_POS] : ie;
    cks_n  = wr_csr ? wdata[1:0] : cks;
    run    = run_reg[START_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_reg <= '0;
      flag    <= 1'b0;
      ie      <= 1'b0;
      cks     <= 2'd0;
      irq     <= 1'b0;
    end else begin
      if (wr_run) run_reg <= wdata;
      flag <= flag_n;
      ie   <= ie_n;
      cks  <= cks_n;
      irq  <= flag_n & ie_n;
    end
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int CNT_W     = 16,
  parameter int START_BIT = 0,
  parameter int PRE_SH0   = 3,
  parameter int PRE_STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  import cmt_pkg::*;

  localparam int DW = CNT_W;

  reg_sel_e      sel;
  logic          wr_run, wr_csr, wr_cnt, wr_cmp, rd_any;
  logic [DW-1:0] run_reg;
  logic          run, flag, ie, pending, tick, match_evt;
  logic [1:0]    cks;
  logic [DW-1:0] cnt, cmp, csr_view;

  always_comb begin
    sel    = reg_sel_e'(bus_addr);
    wr_run = bus_en && bus_we && (sel == REG_RUN);
    wr_csr = bus_en && bus_we && (sel == REG_CSR);
    wr_cnt = bus_en && bus_we && (sel == REG_COUNT);
    wr_cmp = bus_en && bus_we && (sel == REG_MATCH);
    rd_any = bus_en && !bus_we;
    csr_view = '0;
    csr_view[FLAG_POS] = flag;
    csr_view[IE_POS]   = ie;
    csr_view[1:0]      = cks;
  end

  cmt_ctrl #(.DW(DW), .START_BIT(START_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .wr_run(wr_run), .wr_csr(wr_csr),
    .wdata(bus_wdata), .match_evt(match_evt), .run_reg(run_reg),
    .run(run), .flag(flag), .ie(ie), .cks(cks), .irq(irq)
  );

  cmt_prescaler #(.SH0(PRE_SH0), .STEP(PRE_STEP), .SELW(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .active(run || pending), .sel(cks), .tick(tick)
  );

  cmt_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .wr_cnt(wr_cnt),
    .wr_cmp(wr_cmp), .wdata(bus_wdata), .cnt(cnt), .cmp(cmp),
    .pending(pending), .match_evt(match_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_any) begin
      case (sel)
        REG_RUN:   bus_rdata <= run_reg;
        REG_CSR:   bus_rdata <= csr_view;
        REG_COUNT: bus_rdata <= cnt;
        default:   bus_rdata <= cmp;
      endcase
    end
  end
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          flag,
  input logic          ie,
  input logic          run,
  input logic          pending,
  input logic          match_evt,
  input logic          wr_csr,
  input logic          csr_wbit,
  input logic [CW-1:0] cnt
);
  AST_IRQ_IS_FLAG_AND_IE: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie)); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !pending) |=> $stable(cnt)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> (cnt == '0 && flag)); // R4
  AST_FLAG_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(match_evt)); // R5
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_csr && !csr_wbit && !match_evt) |=> !flag); // R5
endmodule

bind cmt_channel cmt_channel_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .flag(flag), .ie(ie), .run(run),
  .pending(pending), .match_evt(match_evt), .wr_csr(wr_csr),
  .csr_wbit(bus_wdata[cmt_pkg::FLAG_POS]), .cnt(cnt)
);

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int cyc = 0, nchk = 0, nfail = 0;
  int cur_cnt = 0;
  bit done = 0;

  cmt_channel u_dut (.clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int divof(int cks);
    return 8 << (2 * cks);
  endfunction

  // returns {flag, count} after n ticks
  function automatic logic [16:0] model(int c0, int cmpv, int n);
    logic [15:0] c = 16'(c0);
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == 16'(cmpv)) begin c = '0; f = 1'b1; end
      else c = c + 16'd1;
    end
    return {f, c};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input int at, output int t);
    while (cyc < at) @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); t = cyc;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input int at, output logic [15:0] d);
    while (cyc < at) @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic trial(int cks, int cmpv, int c0, int g, bit ien);
    int t, tw, ts, te, dv;
    logic [15:0] d;
    logic [16:0] m;
    dv = divof(cks);
    wr(2'd0, 16'h0, 0, t);
    wr(2'd1, 16'((ien << 6) | cks), 0, t);
    wr(2'd3, 16'(cmpv), 0, t);
    wr(2'd2, 16'(c0), 0, tw);
    rd(2'd2, tw + dv + 1, d);
    chk("R7", d, 32'(cur_cnt), "count before second tick");
    rd(2'd2, tw + 2 * dv + 1, d);
    chk("R7", d, 32'(c0), "count after second tick");
    wr(2'd0, 16'h0001, 0, ts);
    wr(2'd0, 16'h0000, ts + g, te);
    m = model(c0, cmpv, (te - ts) / dv);
    rd(2'd2, 0, d);
    chk("R3 R4", d, 32'(m[15:0]), "count after run");
    rd(2'd1, 0, d);
    chk("R4 R8", d, 32'({m[16], ien, 4'b0, 2'(cks)}), "csr after run");
    chk("R6", irq, 32'(m[16] & ien), "irq after run");
    cur_cnt = m[15:0];
  endtask

  initial begin
    int t, ts, tw;
    logic [15:0] d;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 0;
    rd(2'd0, 0, d); chk("R1", d, 0, "run reg reset");
    rd(2'd1, 0, d); chk("R1", d, 0, "csr reset");
    rd(2'd2, 0, d); chk("R1", d, 0, "count reset");
    rd(2'd3, 0, d); chk("R1", d, 32'hffff, "compare reset");
    chk("R1", irq, 0, "irq reset");

    // R2: other channels' bits stored but do not run this one
    wr(2'd0, 16'hfffe, 0, t);
    rd(2'd0, 0, d); chk("R2", d, 32'hfffe, "run reg readback");
    repeat (100) @(negedge clk);
    rd(2'd2, 0, d); chk("R2", d, 0, "count idle with foreign bits");

    // directed: every divider, then random
    trial(0, 5, 2, 200, 1);
    trial(1, 3, 0, 700, 1);
    trial(2, 7, 7, 1100, 0);
    trial(3, 2, 1, 512 * 4 + 100, 1);
    trial(0, 100, 0, 80, 1);
    for (int i = 0; i < 12; i++) begin
      int cks = $urandom % 3;
      int cm = $urandom % 12;
      int c0 = $urandom % (cm + 1);
      trial(cks, cm, c0, 50 + ($urandom % 1500), 1'($urandom % 2));
    end

    // R5/R6: flag kept by write with bit 7 set, cleared by zero
    trial(0, 1, 0, 100, 1);
    wr(2'd1, 16'h00c0, 0, t);
    rd(2'd1, 0, d); chk("R5", d[7], 1, "flag kept by write of one");
    chk("R6", irq, 1, "irq held while flag set");
    wr(2'd1, 16'h0040, 0, t);
    rd(2'd1, 0, d); chk("R5", d[7], 0, "flag cleared by zero");
    chk("R6", irq, 0, "irq low after clear");
    wr(2'd1, 16'h00c0, 0, t);
    rd(2'd1, 0, d); chk("R5", d[7], 0, "write of one does not set flag");
    wr(2'd1, 16'h0000, 0, t);
    rd(2'd1, 0, d); chk("R6", d, 0, "csr zero");

    // R5: clear write in a match cycle loses to the match
    wr(2'd1, 16'h0040, 0, t);
    wr(2'd3, 16'h0000, 0, t);
    wr(2'd2, 16'h0000, 0, tw);
    ts = tw + 2 * 8 + 2;
    wr(2'd0, 16'h0001, ts, ts);
    wr(2'd1, 16'h0040, ts + 16, t);
    rd(2'd1, 0, d); chk("R5", d[7], 1, "match beats clearing write");
    wr(2'd1, 16'h0040, ts + 20, t);
    rd(2'd1, 0, d); chk("R5", d[7], 0, "clear between ticks");
    wr(2'd0, 16'h0000, 0, t);
    wr(2'd1, 16'h0000, 0, t);
    chk("R6", irq, 0, "irq off after csr zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule